// File: doc/BRIEF.md
# Console Address and Byte-Enable Staging

This block holds the address state that a debug console port uses when it reaches into the memory of a 16-bit processor with a 22-bit physical address space. Software on the console side loads a word address in two halves, along with two address-mode enables (22-bit mode and map mode). It also loads a byte-enable setting, which carries a sticky option.

Memory commands then arrive as single-cycle strobes. For each strobe the block presents, one cycle later, the address, the remote-access flag, the byte enables and the mode enables. A command comes in one of three forms:

- **Plain:** uses the staged address as it is.
- **Auto-increment:** uses the staged address, then advances it by one word.
- **Internal-register window:** ignores the staged address and builds one in a fixed window from an offset supplied with the command.

The word address is carried as bits 21:1. Byte bit 0 is never stored.

Top module: `cons_addr_stage`

## Requirements
- R1: A synchronous active-high reset clears the staged word address and both mode enables. It sets the staged byte enables to 11, clears the sticky bit and drives `o_valid` low.
- R2: A pulse on `wr_lo` does four things. It loads staged address bits 15:1 from `wdata[15:1]`, ignoring `wdata[0]`. It clears address bits 21:16. It clears both mode enables. If `wr_hi` is pulsed in the same cycle, `wr_lo` wins.
- R3: A pulse on `wr_hi` loads address bits 21:16 from `wdata[5:0]`, the 22-bit enable from `wdata[6]` and the map enable from `wdata[7]`. It leaves address bits 15:1 unchanged and ignores `wdata[15:8]`.
- R4: A pulse on `wr_be` loads the byte enables from `wdata[1:0]` and the sticky bit from `wdata[2]`.
- R5: A `cmd_go` pulse without `cmd_win` produces, in the next cycle only, `o_valid`=1 together with the following outputs:
  - the staged word address;
  - `o_remote`=0;
  - `o_be`=11;
  - the staged mode enables.
- R6: A `cmd_go` pulse with `cmd_win` produces, in the next cycle, `o_valid`=1 together with the following outputs:
  - an address whose bits 15:13 are 111, bits 12:1 equal `cmd_off` and bits 21:16 are zero;
  - `o_remote`=1;
  - `o_be` equal to the staged byte enables;
  - both mode enables low.

  The staged address is not altered.
- R7: A command with `cmd_inc` set and `cmd_win` clear advances the staged word address by one, wrapping modulo 2^21, and leaves the mode enables unchanged. A command without `cmd_inc`, or with `cmd_win` set, leaves the staged address unchanged.
- R8: A command with `cmd_wr` set while the sticky bit is clear returns the byte enables to 11 once that command has been presented. With the sticky bit set they are kept. Read commands never change them.
- R9: When a register write and a command fall in the same cycle, the command presents the state from before the write, and the register write takes priority over the increment and the byte-enable reversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_lo | input | 1 | Load low address word from `wdata` |
| wr_hi | input | 1 | Load high address bits and mode enables from `wdata` |
| wr_be | input | 1 | Load byte enables and sticky bit from `wdata` |
| wdata | input | 16 | Register write data |
| cmd_go | input | 1 | Memory command strobe |
| cmd_wr | input | 1 | Command is a memory write |
| cmd_inc | input | 1 | Auto-increment variant |
| cmd_win | input | 1 | Internal-register window access |
| cmd_off | input | 12 | Window word offset (address bits 12:1) |
| o_valid | output | 1 | Presented command valid, one cycle |
| o_waddr | output | 21 | Presented word address (bits 21:1) |
| o_remote | output | 1 | Remote-access flag |
| o_be | output | 2 | Presented byte enables |
| o_en22 | output | 1 | Presented 22-bit enable |
| o_enmap | output | 1 | Presented map enable |

## Verification
The bench builds the block with its default widths: a 22-bit physical address, a 16-bit data word and a 13-bit window. At these widths the window offset space of 4096 words can be swept completely, every combination of the eight high-register bits can be written, and all eight byte-enable settings can be tried with both read and write commands. The largest staged address can be loaded directly, so the increment wrap from all ones to zero is checked. Register writes are placed in the same cycle as commands to confirm which source wins.

// File: rtl/cons_stage_pkg.sv
package cons_stage_pkg;

  typedef enum logic [1:0] {
    OP_PLAIN = 2'd0,
    OP_INC   = 2'd1,
    OP_WIN   = 2'd2
  } op_e;

  localparam int BE_W       = 2;
  localparam int STICKY_POS = 2;

  function automatic op_e classify(input logic win, input logic inc);
    if (win)      return OP_WIN;
    else if (inc) return OP_INC;
    else          return OP_PLAIN;
  endfunction

endpackage

// File: rtl/cons_stage_regs.sv
module cons_stage_regs
  import cons_stage_pkg::*;
#(
  parameter int WA_W = 21,
  parameter int DW   = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic            wr_be,
  input  logic [DW-1:0]   wdata,
  input  logic            cmd_go,
  input  logic            cmd_wr,
  input  op_e             op,
  output logic [WA_W-1:0] st_waddr,
  output logic            st_en22,
  output logic            st_enmap,
  output logic [BE_W-1:0] st_be,
  output logic            st_sticky
);
  localparam int LO_F = DW - 1;
  localparam int HI_F = WA_W - LO_F;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_waddr <= '0;
      st_en22  <= 1'b0;
      st_enmap <= 1'b0;
    end else if (wr_lo) begin
      st_waddr <= WA_W'(wdata[DW-1:1]);
      st_en22  <= 1'b0;
      st_enmap <= 1'b0;
    end else if (wr_hi) begin
      st_waddr[WA_W-1:LO_F] <= wdata[HI_F-1:0];
      st_en22               <= wdata[HI_F];
      st_enmap              <= wdata[HI_F+1];
    end else if (cmd_go && op == OP_INC) begin
      st_waddr <= st_waddr + WA_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_be     <= '1;
      st_sticky <= 1'b0;
    end else if (wr_be) begin
      st_be     <= wdata[BE_W-1:0];
      st_sticky <= wdata[STICKY_POS];
    end else if (cmd_go && cmd_wr && !st_sticky) begin
      st_be <= '1;
    end
  end

endmodule

// File: rtl/cons_addr_mux.sv
module cons_addr_mux
  import cons_stage_pkg::*;
#(
  parameter int WA_W  = 21,
  parameter int LO_F  = 15,
  parameter int OFF_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_go,
  input  op_e              op,
  input  logic [OFF_W-1:0] cmd_off,
  input  logic [WA_W-1:0]  st_waddr,
  input  logic             st_en22,
  input  logic             st_enmap,
  input  logic [BE_W-1:0]  st_be,
  output logic             o_valid,
  output logic [WA_W-1:0]  o_waddr,
  output logic             o_remote,
  output logic [BE_W-1:0]  o_be,
  output logic             o_en22,
  output logic             o_enmap
);
  logic [WA_W-1:0] win_addr;

  always_comb begin
    win_addr                  = '0;
    win_addr[LO_F-1:OFF_W]    = '1;
    win_addr[OFF_W-1:0]       = cmd_off;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid  <= 1'b0;
      o_waddr  <= '0;
      o_remote <= 1'b0;
      o_be     <= '1;
      o_en22   <= 1'b0;
      o_enmap  <= 1'b0;
    end else begin
      o_valid <= cmd_go;
      if (cmd_go) begin
        case (op)
          OP_WIN: begin
            o_waddr  <= win_addr;
            o_remote <= 1'b1;
            o_be     <= st_be;
            o_en22   <= 1'b0;
            o_enmap  <= 1'b0;
          end
          default: begin
            o_waddr  <= st_waddr;
            o_remote <= 1'b0;
            o_be     <= '1;
            o_en22   <= st_en22;
            o_enmap  <= st_enmap;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/cons_addr_stage.sv
module cons_addr_stage
  import cons_stage_pkg::*;
#(
  parameter int PA_W  = 22,
  parameter int DW    = 16,
  parameter int WIN_W = 13
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_lo,
  input  logic                 wr_hi,
  input  logic                 wr_be,
  input  logic [DW-1:0]        wdata,
  input  logic                 cmd_go,
  input  logic                 cmd_wr,
  input  logic                 cmd_inc,
  input  logic                 cmd_win,
  input  logic [WIN_W-2:0]     cmd_off,
  output logic                 o_valid,
  output logic [PA_W-2:0]      o_waddr,
  output logic                 o_remote,
  output logic [BE_W-1:0]      o_be,
  output logic                 o_en22,
  output logic                 o_enmap
);
  localparam int WA_W  = PA_W - 1;
  localparam int LO_F  = DW - 1;
  localparam int OFF_W = WIN_W - 1;

  op_e             op;
  logic [WA_W-1:0] st_waddr;
  logic            st_en22;
  logic            st_enmap;
  logic [BE_W-1:0] st_be;
  logic            st_sticky;

  assign op = classify(cmd_win, cmd_inc);

  cons_stage_regs #(.WA_W(WA_W), .DW(DW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_lo    (wr_lo),
    .wr_hi    (wr_hi),
    .wr_be    (wr_be),
    .wdata    (wdata),
    .cmd_go   (cmd_go),
    .cmd_wr   (cmd_wr),
    .op       (op),
    .st_waddr (st_waddr),
    .st_en22  (st_en22),
    .st_enmap (st_enmap),
    .st_be    (st_be),
    .st_sticky(st_sticky)
  );

  cons_addr_mux #(.WA_W(WA_W), .LO_F(LO_F), .OFF_W(OFF_W)) u_mux (
    .clk     (clk),
    .rst     (rst),
    .cmd_go  (cmd_go),
    .op      (op),
    .cmd_off (cmd_off),
    .st_waddr(st_waddr),
    .st_en22 (st_en22),
    .st_enmap(st_enmap),
    .st_be   (st_be),
    .o_valid (o_valid),
    .o_waddr (o_waddr),
    .o_remote(o_remote),
    .o_be    (o_be),
    .o_en22  (o_en22),
    .o_enmap (o_enmap)
  );

endmodule

// File: rtl/cons_addr_stage_chk.sv
module cons_addr_stage_chk #(
  parameter int WA_W  = 21,
  parameter int DW    = 16,
  parameter int OFF_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_lo,
  input logic             wr_hi,
  input logic             wr_be,
  input logic [DW-1:0]    wdata,
  input logic             cmd_go,
  input logic             cmd_wr,
  input logic             cmd_inc,
  input logic             cmd_win,
  input logic [OFF_W-1:0] cmd_off,
  input logic [WA_W-1:0]  st_waddr,
  input logic             st_en22,
  input logic             st_enmap,
  input logic [1:0]       st_be,
  input logic             st_sticky,
  input logic             o_valid,
  input logic [WA_W-1:0]  o_waddr,
  input logic             o_remote,
  input logic [1:0]       o_be,
  input logic             o_en22,
  input logic             o_enmap
);
  localparam int LO_F = DW - 1;
  localparam int HI_F = WA_W - LO_F;

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (st_waddr == '0 && !st_en22 && !st_enmap && st_be == 2'b11 && !st_sticky && !o_valid));

  p_lo_load_r2: assert property (@(posedge clk) disable iff (rst)
    wr_lo |=> (st_waddr[WA_W-1:LO_F] == '0 && !st_en22 && !st_enmap &&
               st_waddr[LO_F-1:0] == $past(wdata[DW-1:1])));

  p_hi_load_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_hi && !wr_lo) |=> (st_waddr[WA_W-1:LO_F] == $past(wdata[HI_F-1:0]) &&
                           st_en22 == $past(wdata[HI_F]) && st_enmap == $past(wdata[HI_F+1]) &&
                           $stable(st_waddr[LO_F-1:0])));

  p_be_load_r4: assert property (@(posedge clk) disable iff (rst)
    wr_be |=> (st_be == $past(wdata[1:0]) && st_sticky == $past(wdata[2])));

  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    cmd_go |=> o_valid);

  p_valid_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !cmd_go |=> !o_valid);

  p_plain_be_r5: assert property (@(posedge clk) disable iff (rst)
    (o_valid && !o_remote) |-> o_be == 2'b11);

  p_win_shape_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_go && cmd_win) |=> (o_remote && !o_en22 && !o_enmap &&
                             o_waddr[LO_F-1:OFF_W] == '1 && o_waddr[WA_W-1:LO_F] == '0 &&
                             o_waddr[OFF_W-1:0] == $past(cmd_off)));

  p_inc_step_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_go && cmd_inc && !cmd_win && !wr_lo && !wr_hi) |=>
      (st_waddr == $past(st_waddr) + WA_W'(1) && $stable(st_en22) && $stable(st_enmap)));

  p_addr_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_go && (!cmd_inc || cmd_win) && !wr_lo && !wr_hi) |=> $stable(st_waddr));

  p_be_revert_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_go && cmd_wr && !st_sticky && !wr_be) |=> st_be == 2'b11);

  p_be_keep_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_go && (!cmd_wr || st_sticky) && !wr_be) |=> $stable(st_be));

endmodule

bind cons_addr_stage cons_addr_stage_chk #(
  .WA_W (PA_W - 1),
  .DW   (DW),
  .OFF_W(WIN_W - 1)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_lo    (wr_lo),
  .wr_hi    (wr_hi),
  .wr_be    (wr_be),
  .wdata    (wdata),
  .cmd_go   (cmd_go),
  .cmd_wr   (cmd_wr),
  .cmd_inc  (cmd_inc),
  .cmd_win  (cmd_win),
  .cmd_off  (cmd_off),
  .st_waddr (st_waddr),
  .st_en22  (st_en22),
  .st_enmap (st_enmap),
  .st_be    (st_be),
  .st_sticky(st_sticky),
  .o_valid  (o_valid),
  .o_waddr  (o_waddr),
  .o_remote (o_remote),
  .o_be     (o_be),
  .o_en22   (o_en22),
  .o_enmap  (o_enmap)
);

// File: tb/cons_addr_stage_tb.sv
`timescale 1ns/1ps
module cons_addr_stage_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_lo = 0, wr_hi = 0, wr_be = 0;
  logic [15:0] wdata = '0;
  logic        cmd_go = 0, cmd_wr = 0, cmd_inc = 0, cmd_win = 0;
  logic [11:0] cmd_off = '0;
  logic        o_valid, o_remote, o_en22, o_enmap;
  logic [20:0] o_waddr;
  logic [1:0]  o_be;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [20:0] m_waddr;
  logic        m_e22, m_emap, m_st;
  logic [1:0]  m_be;

  always #4 clk = ~clk;

  cons_addr_stage u_dut (
    .clk(clk), .rst(rst), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_be(wr_be), .wdata(wdata),
    .cmd_go(cmd_go), .cmd_wr(cmd_wr), .cmd_inc(cmd_inc), .cmd_win(cmd_win), .cmd_off(cmd_off),
    .o_valid(o_valid), .o_waddr(o_waddr), .o_remote(o_remote), .o_be(o_be),
    .o_en22(o_en22), .o_enmap(o_enmap)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, capture at posedge, check at the following negedge.
  task automatic step(input string req, input logic lo, input logic hi, input logic be,
                      input logic [15:0] d, input logic go, input logic wr,
                      input logic inc, input logic win, input logic [11:0] off);
    logic [26:0] exp;
    if (win) exp = {9'b000000111, off, 1'b1, m_be, 2'b00};
    else     exp = {m_waddr, 1'b0, 2'b11, m_e22, m_emap};
    wr_lo = lo; wr_hi = hi; wr_be = be; wdata = d;
    cmd_go = go; cmd_wr = wr; cmd_inc = inc; cmd_win = win; cmd_off = off;
    @(posedge clk);
    @(negedge clk);
    wr_lo = 0; wr_hi = 0; wr_be = 0; cmd_go = 0;
    check({req, " valid"}, 32'(o_valid), 32'(go));
    if (go) check(req, 32'({o_waddr, o_remote, o_be, o_en22, o_enmap}), 32'(exp));
    if (lo) begin
      m_waddr = {6'b0, d[15:1]}; m_e22 = 0; m_emap = 0;
    end else if (hi) begin
      m_waddr[20:15] = d[5:0]; m_e22 = d[6]; m_emap = d[7];
    end else if (go && inc && !win) begin
      m_waddr = m_waddr + 21'd1;
    end
    if (be) begin
      m_be = d[1:0]; m_st = d[2];
    end else if (go && wr && !m_st) begin
      m_be = 2'b11;
    end
  endtask

  task automatic peek(input string req);
    step(req, 0, 0, 0, 16'h0, 1, 0, 0, 0, 12'h0);
  endtask

  initial begin
    m_waddr = '0; m_e22 = 0; m_emap = 0; m_be = 2'b11; m_st = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check("R1 valid idle", 32'(o_valid), 32'd0);
    peek("R1 reset state");
    step("R1 reset be", 0, 0, 0, 16'h0, 1, 0, 0, 1, 12'h000);

    // R2 / R3: sweep low and high register writes
    for (int i = 0; i < 256; i++) begin
      step("R3 hi write", 0, 1, 0, {~i[7:0], i[7:0]}, 0, 0, 0, 0, 12'h0);
      peek("R3 hi readback");
      step("R2 lo write", 1, 0, 0, 16'((i * 16'd257) ^ 16'h5a5b), 0, 0, 0, 0, 12'h0);
      peek("R2 lo readback");
    end
    step("R2 lo beats hi", 1, 1, 0, 16'hffff, 0, 0, 0, 0, 12'h0);
    peek("R2 lo priority");

    // R4 / R8: every byte-enable setting with read and write window commands
    for (int b = 0; b < 8; b++) begin
      step("R4 be write", 0, 0, 1, 16'(b), 0, 0, 0, 0, 12'h0);
      step("R8 read keeps be", 0, 0, 0, 16'h0, 1, 0, 0, 1, 12'h123);
      step("R8 write uses be", 0, 0, 0, 16'h0, 1, 1, 0, 1, 12'h456);
      step("R8 be after write", 0, 0, 0, 16'h0, 1, 0, 0, 1, 12'h789);
      step("R8 plain write", 0, 0, 0, 16'h0, 1, 1, 0, 0, 12'h0);
      step("R8 be after plain", 0, 0, 0, 16'h0, 1, 0, 0, 1, 12'h000);
    end

    // R6: full window offset sweep, increment flag must be ignored
    step("R3 flags on", 0, 1, 0, 16'h00c5, 0, 0, 0, 0, 12'h0);
    step("R4 be 01", 0, 0, 1, 16'h0005, 0, 0, 0, 0, 12'h0);
    for (int k = 0; k < 4096; k++)
      step("R6 window", 0, 0, 0, 16'h0, 1, k[0], 1, 1, 12'(k));
    peek("R7 window no inc");

    // R7: increments and wrap
    step("R3 hi max", 0, 1, 0, 16'h00ff, 0, 0, 0, 0, 12'h0);
    for (int j = 0; j < 40; j++)
      step("R7 inc", 0, 0, 0, 16'h0, 1, j[1], 1, 0, 12'h0);
    step("R2 lo max", 1, 0, 0, 16'hfffe, 0, 0, 0, 0, 12'h0);
    step("R3 hi all", 0, 1, 0, 16'h00ff, 0, 0, 0, 0, 12'h0);
    peek("R7 at top");
    step("R7 wrap inc", 0, 0, 0, 16'h0, 1, 0, 1, 0, 12'h0);
    peek("R7 wrapped");
    peek("R7 plain hold");

    // R9: collisions
    step("R9 lo vs inc", 1, 0, 0, 16'h1234, 1, 0, 1, 0, 12'h0);
    peek("R9 lo won");
    step("R9 hi vs inc", 0, 1, 0, 16'h0042, 1, 0, 1, 0, 12'h0);
    peek("R9 hi won");
    step("R4 sticky off", 0, 0, 1, 16'h0001, 0, 0, 0, 0, 12'h0);
    step("R9 be vs revert", 0, 0, 1, 16'h0002, 1, 1, 0, 1, 12'h010);
    step("R9 be won", 0, 0, 0, 16'h0, 1, 0, 0, 1, 12'h020);

    // R1: reset again
    rst = 1;
    @(posedge clk);
    @(negedge clk);
    rst = 0;
    m_waddr = '0; m_e22 = 0; m_emap = 0; m_be = 2'b11; m_st = 0;
    check("R1 valid after reset", 32'(o_valid), 32'd0);
    peek("R1 state after reset");
    step("R1 be after reset", 0, 0, 0, 16'h0, 1, 0, 0, 1, 12'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule